// File: doc/BRIEF.md
# Configurable FIFO with Threshold Flags

This block is a first-in first-out buffer built on an inferred dual-port memory with a registered read port. One parameter chooses between a single-clock build, where the write and read sides share one clock, and a two-clock build, where each side runs on its own clock. In the two-clock build the pointers cross between domains as Gray code. The read side has two further options. One makes the head word appear on the output without a read request (first-word fall-through). The other adds a pipeline register after the memory. That register has its own synchronous reset value, and the two-clock build always includes it.

The buffer reports full, empty, almost-full and almost-empty. Each threshold is a parameter. Full and almost-full are computed in the write domain. Empty and almost-empty are computed in the read domain. Writes made while full and reads made while empty are dropped without changing any state. In the single-clock build, `rd_clk` must be tied to the same clock as `wr_clk`.

Top module: `cfg_fifo`

## Requirements
- R1: While `rst` is high and right after it, `empty` and `almost_empty` are 1, `full` and `almost_full` are 0, and `rd_data` equals `INIT_VAL`.
- R2: In standard read mode without the output register, a read-clock edge with `rd_en` high while not empty places the oldest stored word on `rd_data` after that edge. Words come out in the order they were written.
- R3: `almost_empty` is 1 exactly when the stored word count (words written and not yet fetched from the memory) is at or below `AE_OFS`.
- R4: `almost_full` is 1 exactly when `2**AW` minus the stored word count is at or below `AF_OFS`.
- R5: In standard read mode, `full` is 1 exactly when `2**AW` words are stored, and `empty` is 1 exactly when none are stored.
- R6: A write made while `full` is 1 is dropped. No stored word or pointer changes.
- R7: A read made while the memory holds no word is dropped. `rd_data` holds its value and the read pointer does not move.
- R8: A write and a read in the same single-clock edge leave the count unchanged. At full, the read proceeds and the write is dropped. At empty, the write proceeds and the read is dropped.
- R9: Enabling the output register delays every read word by exactly one read-clock cycle against the build without it.
- R10: When the output register is in use, `oreg_rst` high at a read-clock edge loads `SR_VAL` into `rd_data`. When the register is not in use, `oreg_rst` has no effect.
- R11: In fall-through mode, a written word appears on `rd_data` with `empty` low one read-clock edge after the write becomes visible, with no `rd_en`. Each `rd_en` edge then presents the next word, or raises `empty` when no word remains. `rd_en` while `empty` is 1 is ignored.
- R12: In two-clock mode the output register is forced on, so a word appears two read-clock edges after the `rd_en` edge. Order is preserved. `full` rises in the write domain right after the last free slot is written, and falls only after the read pointer has crossed back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Word to store |
| rd_clk | input | 1 | Read-side clock (tie to `wr_clk` in single-clock build) |
| rd_en | input | 1 | Read request (pop in fall-through mode) |
| rd_data | output | DW | Read word |
| rst | input | 1 | Synchronous active-high reset for both sides |
| oreg_rst | input | 1 | Synchronous reset of the output register to `SR_VAL` |
| full | output | 1 | No free slot |
| almost_full | output | 1 | Free slots at or below `AF_OFS` |
| empty | output | 1 | No word available to the reader |
| almost_empty | output | 1 | Stored words at or below `AE_OFS` |

## Verification
The case most likely to go wrong is a write and a read arriving on the same edge, because the two sides then update the count at once. In the single-clock build the bench holds `wr_en` and `rd_en` high together at three occupancies: empty, one word, and full. At empty it expects the write to land and the read to be dropped. At one word it expects the count to stay put while the words stream through in order. At full it expects the read to pop and the write to be dropped, which it confirms by draining the buffer and looking for the dropped word.

// File: rtl/cfg_fifo_pkg.sv
`timescale 1ns/1ps
package cfg_fifo_pkg;

  // Read-side datapath variant, picked at elaboration.
  typedef enum logic [1:0] {
    PATH_DIRECT   = 2'd0,  // request-driven, memory register only
    PATH_REG      = 2'd1,  // request-driven, plus output register
    PATH_FWFT     = 2'd2,  // fall-through, memory register shows the head
    PATH_FWFT_REG = 2'd3   // fall-through, head held in output register
  } rd_path_e;

  function automatic rd_path_e sel_path(input bit fwft, input bit oreg);
    if (fwft) return oreg ? PATH_FWFT_REG : PATH_FWFT;
    return oreg ? PATH_REG : PATH_DIRECT;
  endfunction

endpackage

// File: rtl/cfg_fifo_ram.sv
`timescale 1ns/1ps
module cfg_fifo_ram #(
  parameter int DW = 8,
  parameter int AW = 9,
  parameter logic [DW-1:0] INIT_VAL = '0
) (
  input  logic          wr_clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rd_clk,
  input  logic          rst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read port, reset to the power-up value.
  always_ff @(posedge rd_clk) begin
    if (rst)     q <= INIT_VAL;
    else if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/cfg_fifo_sync.sv
`timescale 1ns/1ps
module cfg_fifo_sync #(
  parameter int W     = 10,
  parameter bit ASYNC = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] gray_seen;

  if (ASYNC) begin : g_cross
    logic [W-1:0] stage1, stage2;
    always_ff @(posedge clk) begin
      if (rst) begin
        stage1 <= '0;
        stage2 <= '0;
      end else begin
        stage1 <= gray_in;
        stage2 <= stage1;
      end
    end
    assign gray_seen = stage2;
  end else begin : g_same
    assign gray_seen = gray_in;
  end

  // Gray to binary: each bit is the XOR of all Gray bits at or above it.
  always_comb begin
    for (int i = 0; i < W; i++) bin_out[i] = ^(gray_seen >> i);
  end
endmodule

// File: rtl/cfg_fifo_rdpath.sv
`timescale 1ns/1ps
module cfg_fifo_rdpath #(
  parameter int DW = 8,
  parameter cfg_fifo_pkg::rd_path_e PATH = cfg_fifo_pkg::PATH_REG,
  parameter logic [DW-1:0] INIT_VAL = '0,
  parameter logic [DW-1:0] SR_VAL   = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          oreg_rst,
  input  logic          rd_en,
  input  logic          core_empty,
  input  logic [DW-1:0] ram_q,
  output logic          fetch,
  output logic [DW-1:0] rd_data,
  output logic          out_valid
);
  import cfg_fifo_pkg::*;

  if (PATH == PATH_DIRECT) begin : g_direct
    assign fetch     = rd_en & ~core_empty;
    assign rd_data   = ram_q;
    assign out_valid = ~core_empty;

  end else if (PATH == PATH_REG) begin : g_reg
    logic          fetch_d;
    logic [DW-1:0] oreg;
    assign fetch     = rd_en & ~core_empty;
    assign out_valid = ~core_empty;
    always_ff @(posedge clk) begin
      if (rst) begin
        fetch_d <= 1'b0;
        oreg    <= INIT_VAL;
      end else begin
        fetch_d <= fetch;
        if (oreg_rst)     oreg <= SR_VAL;
        else if (fetch_d) oreg <= ram_q;
      end
    end
    assign rd_data = oreg;

  end else if (PATH == PATH_FWFT) begin : g_fwft
    logic head_v;
    assign fetch = ~core_empty & (~head_v | rd_en);
    always_ff @(posedge clk) begin
      if (rst) head_v <= 1'b0;
      else     head_v <= fetch | (head_v & ~rd_en);
    end
    assign rd_data   = ram_q;
    assign out_valid = head_v;

  end else begin : g_fwft_reg
    logic          mid_v, head_v, advance;
    logic [DW-1:0] oreg;
    assign advance = mid_v & (~head_v | rd_en);
    assign fetch   = ~core_empty & (~mid_v | advance);
    always_ff @(posedge clk) begin
      if (rst) begin
        mid_v  <= 1'b0;
        head_v <= 1'b0;
        oreg   <= INIT_VAL;
      end else begin
        mid_v  <= fetch | (mid_v & ~advance);
        head_v <= advance | (head_v & ~rd_en);
        if (oreg_rst)     oreg <= SR_VAL;
        else if (advance) oreg <= ram_q;
      end
    end
    assign rd_data   = oreg;
    assign out_valid = head_v;
  end
endmodule

// File: rtl/cfg_fifo.sv
`timescale 1ns/1ps
module cfg_fifo
  import cfg_fifo_pkg::*;
#(
  parameter int DW      = 8,
  parameter int AW      = 9,
  parameter bit ASYNC   = 1'b1,
  parameter bit FWFT    = 1'b0,
  parameter bit OUT_REG = 1'b1,
  parameter int AE_OFS  = 128,
  parameter int AF_OFS  = 128,
  parameter logic [DW-1:0] INIT_VAL = '0,
  parameter logic [DW-1:0] SR_VAL   = '0
) (
  input  logic          wr_clk,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_clk,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic          rst,
  input  logic          oreg_rst,
  output logic          full,
  output logic          almost_full,
  output logic          empty,
  output logic          almost_empty
);
  localparam int          DEPTH    = 1 << AW;
  localparam bit          USE_OREG = OUT_REG | ASYNC;
  localparam rd_path_e    PATH     = sel_path(FWFT, USE_OREG);
  localparam logic [AW:0] DEPTH_L  = (AW+1)'(DEPTH);
  localparam logic [AW:0] AE_L     = (AW+1)'(AE_OFS);
  localparam logic [AW:0] AF_L     = (AW+1)'(AF_OFS);
  localparam logic [AW:0] ONE      = (AW+1)'(1);

  logic [AW:0] wptr_bin, wptr_gray, rptr_bin, rptr_gray;
  logic [AW:0] rptr_at_w, wptr_at_r, wr_occ, rd_occ;
  logic [AW:0] wptr_nxt, rptr_nxt;
  logic        wr_go, fetch, core_empty, out_valid;
  logic [DW-1:0] ram_q;

  // Write domain
  assign wr_occ      = wptr_bin - rptr_at_w;
  assign full        = (wr_occ == DEPTH_L);
  assign almost_full = ((DEPTH_L - wr_occ) <= AF_L);
  assign wr_go       = wr_en & ~full;
  assign wptr_nxt    = wptr_bin + ONE;

  always_ff @(posedge wr_clk) begin
    if (rst) begin
      wptr_bin  <= '0;
      wptr_gray <= '0;
    end else if (wr_go) begin
      wptr_bin  <= wptr_nxt;
      wptr_gray <= wptr_nxt ^ (wptr_nxt >> 1);
    end
  end

  // Read domain
  assign rd_occ       = wptr_at_r - rptr_bin;
  assign core_empty   = (rd_occ == '0);
  assign almost_empty = (rd_occ <= AE_L);
  assign empty        = ~out_valid;
  assign rptr_nxt     = rptr_bin + ONE;

  always_ff @(posedge rd_clk) begin
    if (rst) begin
      rptr_bin  <= '0;
      rptr_gray <= '0;
    end else if (fetch) begin
      rptr_bin  <= rptr_nxt;
      rptr_gray <= rptr_nxt ^ (rptr_nxt >> 1);
    end
  end

  cfg_fifo_sync #(.W(AW+1), .ASYNC(ASYNC)) u_w2r (
    .clk(rd_clk), .rst(rst), .gray_in(wptr_gray), .bin_out(wptr_at_r));

  cfg_fifo_sync #(.W(AW+1), .ASYNC(ASYNC)) u_r2w (
    .clk(wr_clk), .rst(rst), .gray_in(rptr_gray), .bin_out(rptr_at_w));

  cfg_fifo_ram #(.DW(DW), .AW(AW), .INIT_VAL(INIT_VAL)) u_ram (
    .wr_clk(wr_clk), .we(wr_go), .waddr(wptr_bin[AW-1:0]), .wdata(wr_data),
    .rd_clk(rd_clk), .rst(rst), .re(fetch), .raddr(rptr_bin[AW-1:0]),
    .q(ram_q));

  cfg_fifo_rdpath #(.DW(DW), .PATH(PATH), .INIT_VAL(INIT_VAL),
                    .SR_VAL(SR_VAL)) u_rdpath (
    .clk(rd_clk), .rst(rst), .oreg_rst(oreg_rst), .rd_en(rd_en),
    .core_empty(core_empty), .ram_q(ram_q), .fetch(fetch),
    .rd_data(rd_data), .out_valid(out_valid));
endmodule

// File: rtl/cfg_fifo_chk.sv
`timescale 1ns/1ps
module cfg_fifo_chk #(
  parameter int DW       = 8,
  parameter int AW       = 9,
  parameter bit USE_OREG = 1'b1,
  parameter logic [DW-1:0] SR_VAL = '0
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          rst,
  input logic          wr_en,
  input logic          oreg_rst,
  input logic          full,
  input logic          almost_full,
  input logic          almost_empty,
  input logic          core_empty,
  input logic [AW:0]   wptr,
  input logic [AW:0]   rptr,
  input logic [AW:0]   wr_occ,
  input logic [DW-1:0] rd_data
);
  localparam logic [AW:0] DEPTH_L = (AW+1)'(1 << AW);

  // R6
  no_overflow_chk: assert property (@(posedge wr_clk) disable iff (rst)
    (full && wr_en) |=> $stable(wptr));

  // R7
  no_underflow_chk: assert property (@(posedge rd_clk) disable iff (rst)
    core_empty |=> $stable(rptr));

  // R4
  full_af_chk: assert property (@(posedge wr_clk) disable iff (rst)
    full |-> almost_full);

  // R3
  empty_ae_chk: assert property (@(posedge rd_clk) disable iff (rst)
    core_empty |-> almost_empty);

  // R5
  occ_bound_chk: assert property (@(posedge wr_clk) disable iff (rst)
    wr_occ <= DEPTH_L);

  if (USE_OREG) begin : g_oreg
    // R10
    srst_val_chk: assert property (@(posedge rd_clk) disable iff (rst)
      oreg_rst |=> (rd_data == SR_VAL));
  end
endmodule

bind cfg_fifo cfg_fifo_chk #(.DW(DW), .AW(AW), .USE_OREG(USE_OREG),
                             .SR_VAL(SR_VAL)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst), .wr_en(wr_en),
  .oreg_rst(oreg_rst), .full(full), .almost_full(almost_full),
  .almost_empty(almost_empty), .core_empty(core_empty),
  .wptr(wptr_bin), .rptr(rptr_bin), .wr_occ(wr_occ), .rd_data(rd_data));

// File: tb/sim_cfg_fifo.sv
`timescale 1ns/1ps
module sim_cfg_fifo;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int DEPTH = 16;
  localparam logic [7:0] INITV = 8'hA5;
  localparam logic [7:0] SRV   = 8'h3C;

  logic clk = 1'b0, rclk = 1'b0, rst = 1'b1;
  always #2.5 clk  = ~clk;
  always #3.5 rclk = ~rclk;

  int nchk = 0, nerr = 0;

  // shared stimulus for u0 (plain) and u1 (output register)
  logic a_we = 0, a_re = 0, a_orst = 0;
  logic [7:0] a_wd = 0;
  logic [7:0] d0, d1, d2, d3;
  logic f0, af0, e0, ae0, f1, af1, e1, ae1;
  // fall-through instance u2
  logic f_we = 0, f_re = 0;
  logic [7:0] f_wd = 0;
  logic f2, af2, e2, ae2;
  // two-clock instance u3
  logic x_we = 0, x_re = 0;
  logic [7:0] x_wd = 0;
  logic f3, af3, e3, ae3;

  cfg_fifo #(.DW(DW), .AW(AW), .ASYNC(0), .FWFT(0), .OUT_REG(0), .AE_OFS(3),
    .AF_OFS(2), .INIT_VAL(INITV), .SR_VAL(SRV)) u0 (
    .wr_clk(clk), .wr_en(a_we), .wr_data(a_wd), .rd_clk(clk), .rd_en(a_re),
    .rd_data(d0), .rst(rst), .oreg_rst(a_orst), .full(f0), .almost_full(af0),
    .empty(e0), .almost_empty(ae0));

  cfg_fifo #(.DW(DW), .AW(AW), .ASYNC(0), .FWFT(0), .OUT_REG(1), .AE_OFS(3),
    .AF_OFS(2), .INIT_VAL(INITV), .SR_VAL(SRV)) u1 (
    .wr_clk(clk), .wr_en(a_we), .wr_data(a_wd), .rd_clk(clk), .rd_en(a_re),
    .rd_data(d1), .rst(rst), .oreg_rst(a_orst), .full(f1), .almost_full(af1),
    .empty(e1), .almost_empty(ae1));

  cfg_fifo #(.DW(DW), .AW(AW), .ASYNC(0), .FWFT(1), .OUT_REG(0), .AE_OFS(3),
    .AF_OFS(2), .INIT_VAL(INITV), .SR_VAL(SRV)) u2 (
    .wr_clk(clk), .wr_en(f_we), .wr_data(f_wd), .rd_clk(clk), .rd_en(f_re),
    .rd_data(d2), .rst(rst), .oreg_rst(1'b0), .full(f2), .almost_full(af2),
    .empty(e2), .almost_empty(ae2));

  cfg_fifo #(.DW(DW), .AW(AW), .ASYNC(1), .FWFT(0), .OUT_REG(0), .AE_OFS(3),
    .AF_OFS(2), .INIT_VAL(INITV), .SR_VAL(SRV)) u3 (
    .wr_clk(clk), .wr_en(x_we), .wr_data(x_wd), .rd_clk(rclk), .rd_en(x_re),
    .rd_data(d3), .rst(rst), .oreg_rst(1'b0), .full(f3), .almost_full(af3),
    .empty(e3), .almost_empty(ae3));

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic rstep();
    @(posedge rclk); @(negedge rclk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nerr);
    $finish;
  endtask

  initial begin
    #1_000_000;
    nchk++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (6) step();
    rst = 1'b0;
    // R1 reset state
    chk("R1 u0 empty", int'(e0), 1);   chk("R1 u0 almost_empty", int'(ae0), 1);
    chk("R1 u0 full", int'(f0), 0);    chk("R1 u0 almost_full", int'(af0), 0);
    chk("R1 u0 rd_data", int'(d0), int'(INITV));
    chk("R1 u1 rd_data", int'(d1), int'(INITV));
    chk("R1 u3 empty", int'(e3), 1);   chk("R1 u3 rd_data", int'(d3), int'(INITV));

    // R3 R4 R5 fill sweep
    for (int k = 1; k <= DEPTH; k++) begin
      a_we = 1'b1; a_wd = 8'(8'h10 + k);
      step();
      chk("R5 full", int'(f0), int'(k == DEPTH));
      chk("R5 empty", int'(e0), 0);
      chk("R3 almost_empty", int'(ae0), int'(k <= 3));
      chk("R4 almost_full", int'(af0), int'((DEPTH - k) <= 2));
    end
    // R6 write while full is dropped
    a_wd = 8'hEE; step(); a_we = 1'b0;
    chk("R6 full held", int'(f0), 1);

    // R2 drain in order, R9 u1 lags one cycle
    a_re = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      step();
      chk("R2 order", int'(d0), 8'h11 + i);
      chk("R9 lag", int'(d1), (i == 0) ? int'(INITV) : 8'h11 + i - 1);
    end
    a_re = 1'b0;
    chk("R5 empty after drain", int'(e0), 1);
    step();
    chk("R9 last word", int'(d1), 8'h20);

    // R7 read while empty
    a_re = 1'b1; step(); a_re = 1'b0;
    chk("R7 data held", int'(d0), 8'h20);
    chk("R7 still empty", int'(e0), 1);
    a_we = 1'b1; a_wd = 8'h55; step(); a_we = 1'b0;
    a_re = 1'b1; step(); a_re = 1'b0;
    chk("R7 pointer unmoved", int'(d0), 8'h55);
    chk("R7 empty again", int'(e0), 1);

    // R8 concurrent at empty: write lands, read dropped
    a_we = 1'b1; a_re = 1'b1; a_wd = 8'h61; step();
    chk("R8 empty-write", int'(e0), 0);
    chk("R8 empty-read dropped", int'(d0), 8'h55);
    // R8 concurrent at one word: count steady
    for (int j = 0; j < 3; j++) begin
      a_wd = 8'(8'h62 + j); step();
      chk("R8 stream data", int'(d0), 8'h61 + j);
      chk("R8 stream count", int'(ae0) + 2 * int'(e0), 1);
    end
    a_re = 1'b0;
    for (int i = 0; i < DEPTH - 1; i++) begin
      a_wd = 8'(8'h70 + i); step();
    end
    chk("R5 refill full", int'(f0), 1);
    // R8 concurrent at full: read pops, write dropped
    a_re = 1'b1; a_wd = 8'hDD; step(); a_we = 1'b0;
    chk("R8 full-read", int'(d0), 8'h64);
    chk("R8 full-write dropped", int'(f0), 0);
    chk("R4 one free", int'(af0), 1);
    for (int i = 0; i < DEPTH - 1; i++) begin
      step();
      chk("R8 drain after full", int'(d0), 8'h70 + i);
    end
    a_re = 1'b0;
    chk("R8 no extra word", int'(e0), 1);
    step();

    // R10 output register reset
    a_orst = 1'b1; step(); a_orst = 1'b0;
    chk("R10 oreg value", int'(d1), int'(SRV));
    chk("R10 no effect without oreg", int'(d0), 8'h7E);

    // R11 fall-through
    f_we = 1'b1; f_wd = 8'h91; step(); f_we = 1'b0;
    chk("R11 not yet visible", int'(e2), 1);
    step();
    chk("R11 shown without rd_en", int'(e2), 0);
    chk("R11 head word", int'(d2), 8'h91);
    f_we = 1'b1; f_wd = 8'h92; step(); f_wd = 8'h93; step(); f_we = 1'b0;
    chk("R11 head stable", int'(d2), 8'h91);
    f_re = 1'b1;
    step(); chk("R11 pop1", int'(d2), 8'h92);
    step(); chk("R11 pop2", int'(d2), 8'h93);
    step(); chk("R11 drained", int'(e2), 1);
    step(); chk("R11 rd_en while empty", int'(e2), 1);
    f_re = 1'b0;
    f_we = 1'b1; f_wd = 8'h94; step(); f_we = 1'b0; step();
    chk("R11 next word", int'(d2), 8'h94);
    chk("R11 visible", int'(e2), 0);

    // R12 two-clock mode
    for (int i = 0; i < 20; i++) begin
      x_we = 1'b1; x_wd = 8'(8'h40 + i); step();
    end
    x_we = 1'b0;
    chk("R12 full in write domain", int'(f3), 1);
    repeat (8) rstep();
    chk("R12 not empty", int'(e3), 0);
    for (int k = 0; k < DEPTH; k++) begin
      x_re = 1'b1; rstep();
      chk("R12 forced oreg order", int'(d3), (k == 0) ? int'(INITV) : 8'h40 + k - 1);
    end
    x_re = 1'b0; rstep();
    chk("R12 last word", int'(d3), 8'h4F);
    chk("R12 empty", int'(e3), 1);
    repeat (6) step();
    chk("R12 full cleared", int'(f3), 0);
    chk("R12 almost_full cleared", int'(af3), 0);

    finish_run();
  end
endmodule